// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a 16 KB scratchpad made of 16 independent banks, each one 32-bit word wide and 256 rows deep. One request carries a word address for each of 16 threads, an active mask, one read/write flag for the whole group and per-thread write data. The block accepts the group and then works through it over one or more clock cycles. In each cycle every bank serves at most one word. The low four address bits pick the bank and the upper bits pick the row.

When threads in a group aim at different words of the same bank, those accesses are spread over successive cycles. In each bank the lowest-numbered pending thread picks the word served in a cycle. Every pending thread that asks for that same word is served with it, so repeated reads of one word cost a single cycle. When the last access is done, a one-cycle completion strobe presents the read data of all lanes and the number of service cycles the group needed. That number is the largest count of distinct words requested in any single bank. Groups are handled strictly one after another and never interact.

Top module: `bank_serializer`

## Requirements
- R1: After reset `busy` and `done` are low, `cycles` is 0 and every lane of `rd_data` is 0.
- R2: Word address A is stored in bank A mod 16 at row A div 16. A read of A returns the last value written to A. Thread t uses address bits [12t+11:12t] and data bits [32t+31:32t].
- R3: A group is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the following cycle. Any request presented while `busy` is high is ignored and does not touch the storage.
- R4: `busy` stays high for exactly N cycles, where N is the number of service cycles. `done` is high in the cycle right after the last one.
- R5: N equals the largest number of distinct words requested by active threads in any one bank. A linear pattern with an odd stride gives 1, stride 2 gives 2, stride 4 gives 4, stride 8 gives 8 and stride 16 gives 16.
- R6: Several reads of the same word within a group are merged into one access. If every active thread reads one word, the group needs 1 cycle.
- R7: `req_write`=1 marks a write group. If several threads of one write group write the same word, the value from the highest-numbered thread is kept.
- R8: When a group is accepted, all `rd_data` lanes are cleared. Lanes of inactive threads, and every lane of a write group, read 0 at `done`.
- R9: `done` is a one-cycle pulse. `rd_data` and `cycles` keep their values until the next group is accepted.
- R10: A group with an all-zero mask keeps `busy` high for one cycle and reports `cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Present a group of accesses |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_mask | input | 16 | Active thread mask, bit t = thread t |
| req_addr | input | 16x12 | Word address per thread |
| req_wdata | input | 16x32 | Write data per thread |
| busy | output | 1 | Group in service |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 16x32 | Read data per thread |
| cycles | output | 5 | Service cycles used by the last group |

## Verification
Every cycle, the assertions check the following. An accepted request raises `busy` in the next cycle. The pending set shrinks in each service cycle. `done` is a single pulse that follows busy, and it never reports a count above the thread count. A write group leaves the read lanes at zero. The exact cycle counts for strided, broadcast and partly merged patterns, and the winner of a same-word write, depend on the data. Only the bench scenarios can show these, and the same holds for the stored values and for the fact that a request made during busy is ignored.

// File: rtl/bank_serializer.sv
module bank_serializer #(
  parameter int THREADS = 16,
  parameter int BANKS   = 16,
  parameter int ROWS    = 256,
  parameter int DW      = 32,
  localparam int BW = $clog2(BANKS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = BW + RW,
  localparam int CW = $clog2(THREADS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [THREADS-1:0]               req_mask,
  input  logic [THREADS-1:0][AW-1:0]       req_addr,
  input  logic [THREADS-1:0][DW-1:0]       req_wdata,
  output logic                             busy,
  output logic                             done,
  output logic [THREADS-1:0][DW-1:0]       rd_data,
  output logic [CW-1:0]                    cycles
);

  logic                       busy_q, done_q, wr_q;
  logic [THREADS-1:0]         pend_q, hit;
  logic [THREADS-1:0][AW-1:0] addr_q;
  logic [THREADS-1:0][DW-1:0] wdat_q, rd_q;
  logic [CW-1:0]              cnt_q;

  logic [BANKS-1:0][RW-1:0]   sel_row;
  logic [BANKS-1:0]           bank_we;
  logic [BANKS-1:0][DW-1:0]   bank_wd, bank_rd;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      sel_row[b] = '0;
      for (int t = THREADS - 1; t >= 0; t--)
        if (pend_q[t] && addr_q[t][BW-1:0] == BW'(b))
          sel_row[b] = addr_q[t][AW-1:BW];
    end
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++)
      hit[t] = pend_q[t] && (sel_row[addr_q[t][BW-1:0]] == addr_q[t][AW-1:BW]);
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_we[b] = 1'b0;
      bank_wd[b] = '0;
      for (int t = 0; t < THREADS; t++)
        if (hit[t] && wr_q && addr_q[t][BW-1:0] == BW'(b)) begin
          bank_we[b] = 1'b1;
          bank_wd[b] = wdat_q[t];
        end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] ram [ROWS];
    always_ff @(posedge clk)
      if (busy_q && bank_we[b]) ram[sel_row[b]] <= bank_wd[b];
    assign bank_rd[b] = ram[sel_row[b]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      pend_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          wr_q   <= req_write;
          pend_q <= req_mask;
          addr_q <= req_addr;
          wdat_q <= req_wdata;
          rd_q   <= '0;
          cnt_q  <= '0;
        end
      end else begin
        pend_q <= pend_q & ~hit;
        if (|hit) cnt_q <= cnt_q + CW'(1);
        for (int t = 0; t < THREADS; t++)
          if (hit[t] && !wr_q) rd_q[t] <= bank_rd[addr_q[t][BW-1:0]];
        if ((pend_q & ~hit) == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign cycles  = cnt_q;

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid) |=> busy_q); // R3
  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pend_q != '0) |=> (!busy_q || $countones(pend_q) < $past($countones(pend_q)))); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q) && !busy_q); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> int'(cnt_q) <= THREADS); // R5
  AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && wr_q) |-> rd_q == '0); // R8

endmodule

// File: tb/bank_serializer_tb.sv
module bank_serializer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_mask = '0;
  logic [15:0][11:0] req_addr = '0;
  logic [15:0][31:0] req_wdata = '0;
  logic busy, done;
  logic [15:0][31:0] rd_data;
  logic [4:0] cycles;

  always #5 clk = ~clk;

  bank_serializer u_dut (.clk, .rst_n, .req_valid, .req_write, .req_mask,
    .req_addr, .req_wdata, .busy, .done, .rd_data, .cycles);

  int errs = 0, checks = 0, nb = 0;
  logic [15:0][11:0] addr_v;
  logic [15:0][31:0] wd_v, exp_v, hold_v;

  localparam int NV = 9;
  localparam int VBASE [NV] = '{0, 5, 0, 0, 0, 7, 0, 0, 0};
  localparam int VSTR  [NV] = '{1, 3, 2, 8, 16, 0, 4, 2, 16};
  localparam logic [15:0] VMASK [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
    16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h00FF, 16'h000F};
  localparam int VEXP  [NV] = '{1, 1, 2, 8, 16, 1, 4, 1, 4};

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [15:0] m, input bit poke);
    @(negedge clk);
    req_write = wr; req_mask = m; req_addr = addr_v; req_wdata = wd_v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; nb = 0;
    while (!done) begin
      if (busy) nb++;
      if (poke && nb == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_mask = '1; req_wdata = {16{32'hDEAD0000}};
      end
      if (poke && nb == 4) req_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic chk_data(input string tag);
    int bad = -1;
    for (int t = 0; t < 16; t++) if (bad < 0 && rd_data[t] !== exp_v[t]) bad = t;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, rd_data[bad], exp_v[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(cycles == 0, "R1 cycles", cycles, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data[0], 0);
    rst_n = 1'b1;

    for (int g = 0; g < 256; g++) begin
      for (int t = 0; t < 16; t++) begin
        addr_v[t] = 12'(g * 16 + t); wd_v[t] = pat(g * 16 + t);
      end
      run(1'b1, 16'hFFFF, 1'b0);
      if (g == 0) begin
        chk(cycles == 1, "R4 linear write cycles", cycles, 1);
        chk(rd_data == '0, "R8 write group rd_data", rd_data[0], 0);
      end
    end

    for (int v = 0; v < NV; v++) begin
      for (int t = 0; t < 16; t++) begin
        addr_v[t] = 12'(VBASE[v] + VSTR[v] * t);
        exp_v[t] = VMASK[v][t] ? pat(int'(addr_v[t])) : 32'h0;
      end
      run(1'b0, VMASK[v], 1'b0);
      chk(int'(cycles) == VEXP[v], VSTR[v] == 0 ? "R6 broadcast cycles" : "R5 cycles", cycles, VEXP[v]);
      chk(nb == VEXP[v], "R4 busy length", nb, VEXP[v]);
      chk_data(VMASK[v] == 16'hFFFF ? "R2 read data" : "R8 inactive lanes");
    end

    // R9 hold after done
    hold_v = rd_data;
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(rd_data == hold_v && cycles == 4, "R9 held outputs", cycles, 4);

    // R6 partial merge: two words in bank 3
    for (int t = 0; t < 16; t++) begin
      addr_v[t] = t < 8 ? 12'd3 : 12'd19;
      exp_v[t] = pat(int'(addr_v[t]));
    end
    run(1'b0, 16'hFFFF, 1'b0);
    chk(cycles == 2, "R6 merged cycles", cycles, 2);
    chk_data("R6 merged data");

    // R3 request during busy is ignored
    for (int t = 0; t < 16; t++) begin
      addr_v[t] = 12'(1 + 16 * t); exp_v[t] = pat(1 + 16 * t);
    end
    run(1'b0, 16'hFFFF, 1'b1);
    chk(cycles == 16, "R3 group cycles", cycles, 16);
    run(1'b0, 16'hFFFF, 1'b0);
    chk_data("R3 storage untouched");

    // R10 empty mask
    run(1'b0, 16'h0000, 1'b0);
    chk(cycles == 0, "R10 cycles", cycles, 0);
    chk(nb == 1, "R10 busy length", nb, 1);

    // R7 same-word write, highest thread wins
    for (int t = 0; t < 16; t++) begin
      addr_v[t] = 12'd100; wd_v[t] = 32'(t + 1);
    end
    run(1'b1, 16'hFFFF, 1'b0);
    chk(cycles == 1, "R7 write cycles", cycles, 1);
    run(1'b0, 16'hFFFF, 1'b0);
    exp_v = {16{32'd16}};
    chk_data("R7 all-thread winner");
    for (int t = 0; t < 16; t++) begin
      addr_v[t] = 12'd200; wd_v[t] = 32'h0;
    end
    wd_v[3] = 32'h33; wd_v[9] = 32'h99;
    run(1'b1, 16'h0208, 1'b0);
    run(1'b0, 16'h0001, 1'b0);
    chk(rd_data[0] == 32'h99, "R7 two-thread winner", rd_data[0], 32'h99);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule